// File: doc/BRIEF.md
# Split Cache/SRAM Second-Level Memory

This block is a second-level on-chip memory. Its storage can be divided at run time between directly addressed SRAM and a four-way set-associative cache that sits in front of a slower backing memory. The storage is made of four equal blocks of 1 KB each. A configuration write picks how many of these blocks work as cache, from zero to four. Every block that is not given to the cache stays in the address map as ordinary SRAM. Anything placed there remains on chip for as long as the split leaves the block alone.

The core sees one request port. It holds `req`, the direction, the word address and the write data steady until `ready` pulses. Word addresses below 1024 fall in the internal window. All higher word addresses are external. External reads are cached when at least one cache block exists. With no cache blocks they go straight to backing memory. External writes always go through to backing memory and never allocate a line. Every change of the split clears all cache lines. While that sweep runs, the block holds `busy` high and serves no request.

Top module: `l2_partition`

## Requirements
- R1: Word addresses 0 to 1023 form the internal window. Internal block b covers word addresses 256*b to 256*b+255. An access to a block that is not cache answers with `ready` in the same cycle as `req`, makes no backing-memory transfer, and a read returns the last value written to that word.
- R2: A write of `cfg_blocks` with a value of 0 to 4 in an idle cycle sets the number of cache blocks k, shown on `cfg_cur`. Values of 5 and above are ignored. Writing the value already held changes nothing and starts no sweep.
- R3: The cache uses internal blocks 4-k to 3, so way w is held in block 3-w. An internal access to one of those blocks answers at once with `err`=1 and read data 0, and its write data is discarded. A cached line stored in that block is left intact.
- R4: After k changes, `busy` is high for exactly 32 cycles. During those cycles no request gets `ready` and no backing transfer is made. Afterwards every cache line is invalid.
- R5: With k>0, an external read that hits returns the cached word in the same cycle, with no backing transfer. A miss reads the whole 8-word line from backing memory, starting at offset 0 and going up, installs it, and then returns the requested word.
- R6: An external write makes exactly one backing-memory write. If the line is cached, the cached word is updated too. If the line is not cached, nothing is allocated.
- R7: With k=0, every external read is one single-word backing read, and nothing is cached.
- R8: The cache has 32 sets, indexed by word-address bits [7:3]. The tag is word-address bits [13:8]. Only ways 0 to k-1 are active, so up to k lines that share a set can be resident at once.
- R9: On a read miss, the lowest-numbered invalid active way is filled first. If every active way is valid, a 3-bit tree per set chooses the victim. With k=1 the victim is way 0. With k=2 it is the way that was not touched last. With k=3, a root pointing right selects way 2, and otherwise the left pair decides. With k=4, the root, and then the pair bit, choose the way. A read hit or a fill makes the tree point away from the way used. A write does not change the tree.
- R10: After reset, `cfg_cur` is 0, `busy`, `ready` and `mem_req` are 0, and all cache lines are invalid.
- R11: A change of k leaves the contents of blocks that stay SRAM unchanged.
- R12: `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the cache block count |
| cfg_blocks | input | 3 | Requested number of cache blocks |
| cfg_cur | output | 3 | Number of cache blocks now in effect |
| busy | output | 1 | Invalidation sweep in progress |
| req | input | 1 | Core request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 14 | Word address |
| wdata | input | 32 | Write data |
| ready | output | 1 | Request complete this cycle |
| rdata | output | 32 | Read data, valid with ready |
| err | output | 1 | Access hit a block lent to the cache |
| mem_req | output | 1 | Backing-memory request |
| mem_we | output | 1 | Backing-memory write |
| mem_addr | output | 14 | Backing-memory word address |
| mem_wdata | output | 32 | Backing-memory write data |
| mem_ack | input | 1 | Backing memory completes the transfer |
| mem_rdata | input | 32 | Backing-memory read data |

## Verification
The bench attacks the replacement order with runs of more distinct tags than active ways in one set, for every value of k. A wrong tree update, or a victim chosen from an inactive way, shows up as a miss where a hit was due, or the reverse, and so as a wrong backing-transfer count. It stores a line in way 0 and then writes to the aliased internal address. A design that lets the error write through corrupts the cached word, and the next hit returns the wrong data. It also checks write-through with stale cached data, bypass with k=0, the exact sweep length, and SRAM contents across changes of the split. A missing invalidation shows up as a hit after a sweep. A bad block boundary returns `err` on a live SRAM block, or lets a cache block be reached as SRAM.

// File: rtl/l2p_pkg.sv
package l2p_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 32;
  localparam int NBLK       = 4;
  localparam int BLK_BYTES  = 1024;
  localparam int LINE_BYTES = 32;

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORD_AW    = $clog2(WORD_BYTES);
  localparam int WADDR_W    = ADDR_W - WORD_AW;
  localparam int IDX_W      = $clog2(NBLK * BLK_BYTES) - WORD_AW;
  localparam int BLK_WAW    = $clog2(BLK_BYTES) - WORD_AW;
  localparam int OFF_W      = $clog2(LINE_BYTES) - WORD_AW;
  localparam int SET_W      = BLK_WAW - OFF_W;
  localparam int SETS       = 1 << SET_W;
  localparam int BLK_W      = IDX_W - BLK_WAW;
  localparam int TAG_W      = WADDR_W - BLK_WAW;
  localparam int WAY_W      = $clog2(NBLK);
  localparam int NCFG_W     = $clog2(NBLK + 1);
  localparam int MEM_WORDS  = 1 << IDX_W;
  localparam int LINE_WORDS = 1 << OFF_W;

  typedef logic [2:0] plru_t;   // [0] root, [1] left pair, [2] right pair

  typedef enum logic [2:0] {
    ST_IDLE, ST_SWEEP, ST_FILL, ST_RESP, ST_BREAD, ST_WMEM
  } l2p_state_e;

  function automatic logic blk_is_cache(input logic [BLK_W-1:0] blk,
                                        input logic [NCFG_W-1:0] nact);
    return (int'(blk) + int'(nact)) >= NBLK;
  endfunction

  function automatic logic [IDX_W-1:0] cache_idx(input logic [WAY_W-1:0] way,
                                                 input logic [SET_W-1:0] set,
                                                 input logic [OFF_W-1:0] off);
    logic [BLK_W-1:0] b;
    b = BLK_W'(NBLK - 1 - int'(way));
    return {b, set, off};
  endfunction

  function automatic logic [WAY_W-1:0] plru_victim(input plru_t t,
                                                   input logic [NCFG_W-1:0] nact);
    case (nact)
      NCFG_W'(1): return 2'd0;
      NCFG_W'(2): return {1'b0, t[1]};
      NCFG_W'(3): return t[0] ? 2'd2 : {1'b0, t[1]};
      default:    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endcase
  endfunction

  function automatic plru_t plru_touch(input plru_t t, input logic [WAY_W-1:0] w);
    plru_t r;
    r    = t;
    r[0] = ~w[1];
    if (!w[1]) r[1] = ~w[0];
    else       r[2] = ~w[0];
    return r;
  endfunction
endpackage

// File: rtl/l2p_decode.sv
module l2p_decode
  import l2p_pkg::*;
(
  input  logic [WADDR_W-1:0] waddr,
  input  logic [NCFG_W-1:0]  nact,
  output logic               is_int,
  output logic               int_err,
  output logic [IDX_W-1:0]   sram_idx,
  output logic [SET_W-1:0]   set,
  output logic [OFF_W-1:0]   off,
  output logic [TAG_W-1:0]   tag
);
  logic [BLK_W-1:0] blk;

  assign is_int   = (waddr[WADDR_W-1:IDX_W] == '0);
  assign blk      = waddr[IDX_W-1:BLK_WAW];
  assign sram_idx = waddr[IDX_W-1:0];
  assign set      = waddr[BLK_WAW-1:OFF_W];
  assign off      = waddr[OFF_W-1:0];
  assign tag      = waddr[WADDR_W-1:BLK_WAW];
  assign int_err  = is_int && blk_is_cache(blk, nact);
endmodule

// File: rtl/l2p_tags.sv
module l2p_tags
  import l2p_pkg::*;
#(
  parameter int NWAYS = NBLK,
  parameter int NSETS = SETS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCFG_W-1:0] nact,
  input  logic [SET_W-1:0]  set,
  input  logic [TAG_W-1:0]  tag,
  output logic [NWAYS-1:0]  hit_vec,
  output logic [WAY_W-1:0]  victim,
  input  logic              touch_en,
  input  logic [WAY_W-1:0]  touch_way,
  input  logic              fill_en,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              clr_en,
  input  logic [SET_W-1:0]  clr_set
);
  logic [NSETS-1:0] valid [NWAYS];
  logic [TAG_W-1:0] tagr  [NWAYS][NSETS];
  plru_t            plru  [NSETS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign hit_vec[w] = (w < int'(nact)) && valid[w][set] && (tagr[w][set] == tag);
  end

  always_comb begin
    victim = plru_victim(plru[set], nact);
    for (int w = NWAYS - 1; w >= 0; w--)
      if (w < int'(nact) && !valid[w][set]) victim = WAY_W'(w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWAYS; w++) valid[w] <= '0;
      for (int s = 0; s < NSETS; s++) plru[s] <= '0;
    end else begin
      if (clr_en) begin
        for (int w = 0; w < NWAYS; w++) valid[w][clr_set] <= 1'b0;
        plru[clr_set] <= '0;
      end
      if (fill_en)  valid[fill_way][set] <= 1'b1;
      if (touch_en) plru[set] <= plru_touch(plru[set], touch_way);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tagr[fill_way][set] <= tag;
  end
endmodule

// File: rtl/l2p_data.sv
module l2p_data
  import l2p_pkg::*;
#(
  parameter int DEPTH = MEM_WORDS
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/l2_partition.sv
module l2_partition
  import l2p_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [NCFG_W-1:0]  cfg_blocks,
  output logic [NCFG_W-1:0]  cfg_cur,
  output logic               busy,
  input  logic               req,
  input  logic               we,
  input  logic [WADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               ready,
  output logic [DATA_W-1:0]  rdata,
  output logic               err,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata
);
  l2p_state_e         state;
  logic [WADDR_W-1:0] q_addr;
  logic [DATA_W-1:0]  q_wdata;
  logic [WAY_W-1:0]   q_way;
  logic [OFF_W-1:0]   cnt;
  logic [SET_W-1:0]   sweep_idx;

  logic [WADDR_W-1:0] cur_addr;
  logic               is_int, int_err;
  logic [IDX_W-1:0]   sram_idx;
  logic [SET_W-1:0]   set;
  logic [OFF_W-1:0]   off;
  logic [TAG_W-1:0]   tag;
  logic [NBLK-1:0]    hit_vec;
  logic [WAY_W-1:0]   victim, hit_way;
  logic               any_hit, cache_on;

  // named internal events
  logic cfg_go, ev_accept, ev_sram, ev_ext, ev_rd_hit, ev_wr_hit;
  logic ev_fill_word, ev_fill_last;

  logic               d_we;
  logic [IDX_W-1:0]   d_waddr, d_raddr;
  logic [DATA_W-1:0]  d_wdata, d_rdata;

  assign cur_addr = (state == ST_IDLE) ? addr : q_addr;
  assign cache_on = (cfg_cur != '0);

  l2p_decode u_dec (
    .waddr(cur_addr), .nact(cfg_cur), .is_int(is_int), .int_err(int_err),
    .sram_idx(sram_idx), .set(set), .off(off), .tag(tag)
  );

  assign cfg_go       = (state == ST_IDLE) && cfg_we &&
                        (int'(cfg_blocks) <= NBLK) && (cfg_blocks != cfg_cur);
  assign ev_accept    = (state == ST_IDLE) && req && !cfg_go;
  assign ev_sram      = ev_accept && is_int;
  assign ev_ext       = ev_accept && !is_int;
  assign any_hit      = |hit_vec;
  assign ev_rd_hit    = ev_ext && cache_on && !we && any_hit;
  assign ev_wr_hit    = ev_ext && cache_on && we && any_hit;
  assign ev_fill_word = (state == ST_FILL) && mem_ack;
  assign ev_fill_last = ev_fill_word && (cnt == OFF_W'(LINE_WORDS - 1));

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NBLK; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  l2p_tags u_tags (
    .clk(clk), .rst_n(rst_n), .nact(cfg_cur), .set(set), .tag(tag),
    .hit_vec(hit_vec), .victim(victim),
    .touch_en(ev_rd_hit || ev_fill_last),
    .touch_way(ev_fill_last ? q_way : hit_way),
    .fill_en(ev_fill_last), .fill_way(q_way),
    .clr_en(state == ST_SWEEP), .clr_set(sweep_idx)
  );

  // data array port selection
  assign d_we    = (ev_sram && we && !int_err) || ev_wr_hit || ev_fill_word;
  assign d_waddr = ev_fill_word ? cache_idx(q_way, set, cnt)
                 : (is_int ? sram_idx : cache_idx(hit_way, set, off));
  assign d_wdata = ev_fill_word ? mem_rdata : wdata;
  assign d_raddr = (state == ST_IDLE && is_int) ? sram_idx
                 : cache_idx((state == ST_IDLE) ? hit_way : q_way, set, off);

  l2p_data u_data (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(d_raddr), .rdata(d_rdata)
  );

  // core response
  assign ready = ev_sram || ev_rd_hit || (state == ST_RESP) ||
                 (((state == ST_BREAD) || (state == ST_WMEM)) && mem_ack);
  assign err   = ev_sram && int_err;

  always_comb begin
    rdata = '0;
    if (ev_sram && !int_err)                      rdata = d_rdata;
    else if (ev_rd_hit || (state == ST_RESP))     rdata = d_rdata;
    else if ((state == ST_BREAD) && mem_ack)      rdata = mem_rdata;
  end

  // backing-memory side
  assign mem_req   = (state == ST_FILL) || (state == ST_BREAD) || (state == ST_WMEM);
  assign mem_we    = (state == ST_WMEM);
  assign mem_addr  = (state == ST_FILL) ? {q_addr[WADDR_W-1:OFF_W], cnt} : q_addr;
  assign mem_wdata = q_wdata;
  assign busy      = (state == ST_SWEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_cur   <= '0;
      q_addr    <= '0;
      q_wdata   <= '0;
      q_way     <= '0;
      cnt       <= '0;
      sweep_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cfg_go) begin
            cfg_cur   <= cfg_blocks;
            sweep_idx <= '0;
            state     <= ST_SWEEP;
          end else if (ev_ext) begin
            q_addr  <= addr;
            q_wdata <= wdata;
            q_way   <= victim;
            cnt     <= '0;
            if (we)            state <= ST_WMEM;
            else if (!cache_on) state <= ST_BREAD;
            else if (!any_hit)  state <= ST_FILL;
          end
        end
        ST_SWEEP: begin
          sweep_idx <= sweep_idx + 1'b1;
          if (sweep_idx == SET_W'(SETS - 1)) state <= ST_IDLE;
        end
        ST_FILL: begin
          if (mem_ack) begin
            cnt <= cnt + 1'b1;
            if (ev_fill_last) state <= ST_RESP;
          end
        end
        ST_RESP:  state <= ST_IDLE;
        ST_BREAD: if (mem_ack) state <= ST_IDLE;
        ST_WMEM:  if (mem_ack) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l2p_sva.sv
module l2p_sva
  import l2p_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ready,
  input logic              err,
  input logic              req,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [WADDR_W-1:0] mem_addr,
  input logic [NCFG_W-1:0] cfg_cur,
  input logic [NBLK-1:0]   hit_vec
);
  logic [7:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else        busy_run <= busy ? busy_run + 8'd1 : 8'd0;
  end

  p_busy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ready && !mem_req));

  p_sweep_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(busy_run) < SETS));

  p_err_with_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ready);

  p_ready_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> req);

  p_hit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_bypass_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cur == '0) |-> (hit_vec == '0));

  p_size_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cfg_cur) <= NBLK);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind l2_partition l2p_sva u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready), .err(err), .req(req),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .cfg_cur(cfg_cur), .hit_vec(hit_vec)
);

// File: tb/l2_partition_tb.sv
module l2_partition_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_blocks = '0;
  logic [2:0]  cfg_cur;
  logic        busy;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        err;
  logic        mem_req, mem_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_partition u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_blocks(cfg_blocks),
    .cfg_cur(cfg_cur), .busy(busy), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ready(ready), .rdata(rdata), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  // ---------------- backing memory environment ----------------
  logic [31:0] env [int];
  int tx_cnt = 0;
  int rdq[$];
  bit pend = 0;
  logic [13:0] pend_addr;

  function automatic logic [31:0] init_val(input int w);
    return (32'(w) * 32'h9E3779B1) ^ 32'h00005A5A;
  endfunction

  function automatic logic [31:0] env_rd(input int w);
    return env.exists(w) ? env[w] : init_val(w);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && rst_n) begin
        mem_ack   = 1'b1;
        mem_rdata = env_rd(int'(mem_addr));
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (pend) chk(mem_req && mem_addr == pend_addr, "R12 request held", {18'd0, mem_addr}, {18'd0, pend_addr});
      pend      = mem_req && !mem_ack;
      pend_addr = mem_addr;
      if (mem_req && mem_ack) begin
        tx_cnt++;
        if (mem_we) env[int'(mem_addr)] = mem_wdata;
        else rdq.push_back(int'(mem_addr));
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  int mk = 0;
  bit cval [4][32];
  int ctag [4][32];
  int tr   [32][3];
  logic [31:0] sram [1024];
  bit sknown [1024];
  logic [31:0] refm [int];

  function automatic logic [31:0] ref_rd(input int w);
    return refm.exists(w) ? refm[w] : init_val(w);
  endfunction

  function automatic void touch(input int s, input int w);
    if (w < 2) begin tr[s][0] = 1; tr[s][1] = (w == 0) ? 1 : 0; end
    else       begin tr[s][0] = 0; tr[s][2] = (w == 2) ? 1 : 0; end
  endfunction

  function automatic int pick(input int s);
    for (int w = 0; w < mk; w++) if (!cval[w][s]) return w;
    if (mk == 1) return 0;
    if (mk == 2) return tr[s][1];
    if (mk == 3) return tr[s][0] ? 2 : tr[s][1];
    return tr[s][0] ? 2 + tr[s][2] : tr[s][1];
  endfunction

  task automatic m_access(input bit w, input int a, input logic [31:0] d,
                          output logic [31:0] rd, output bit e, output int tx, output bit cd);
    rd = 0; e = 0; tx = 0; cd = 0;
    if (a < 4096) begin
      int blk = a / 1024;
      if (blk >= 4 - mk) begin e = 1; cd = 1; end
      else begin
        if (w) begin sram[a/4] = d; sknown[a/4] = 1; end
        else begin rd = sram[a/4]; cd = sknown[a/4]; end
      end
    end else if (w) begin
      refm[a/4] = d; tx = 1;
    end else begin
      rd = ref_rd(a/4); cd = 1;
      if (mk == 0) tx = 1;
      else begin
        int s = (a / 32) % 32, t = a / 1024, h = -1;
        for (int k = 0; k < mk; k++) if (cval[k][s] && ctag[k][s] == t) h = k;
        if (h >= 0) touch(s, h);
        else begin
          int v = pick(s);
          tx = 8; cval[v][s] = 1; ctag[v][s] = t; touch(s, v);
        end
      end
    end
  endtask

  // ---------------- stimulus ----------------
  task automatic do_access(input bit w, input int a, input logic [31:0] d,
                           output logic [31:0] rd, output bit e, output int ntx, output int lat);
    int t0;
    t0 = tx_cnt; rdq.delete(); lat = 0;
    @(negedge clk);
    req = 1; we = w; addr = 14'(a >> 2); wdata = d;
    #1;
    while (!ready) begin
      @(negedge clk); #1; lat++;
    end
    rd = rdata; e = err;
    @(posedge clk); #1;
    ntx = tx_cnt - t0;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic run_acc(input bit w, input int a, input logic [31:0] d, input string r);
    logic [31:0] xr, ar; bit xe, ae, cd; int xt, at, lat;
    m_access(w, a, d, xr, xe, xt, cd);
    do_access(w, a, d, ar, ae, at, lat);
    chk(ae == xe, {r, " err"}, {31'd0, ae}, {31'd0, xe});
    if (cd && !w) chk(ar == xr, {r, " rdata"}, ar, xr);
    chk(at == xt, {r, " backing transfers"}, at, xt);
    if (xt == 8 && at == 8)
      for (int k = 0; k < 8; k++)
        chk(rdq[k] == (a / 32) * 8 + k, "R5 fill order", rdq[k], (a / 32) * 8 + k);
  endtask

  function automatic void m_cfg(input int v);
    if (v <= 4 && v != mk) begin
      for (int w = 0; w < 4; w++) for (int s = 0; s < 32; s++) cval[w][s] = 0;
      for (int s = 0; s < 32; s++) for (int b = 0; b < 3; b++) tr[s][b] = 0;
      for (int i = (4 - v) * 256; i < 1024; i++) sknown[i] = 0;
      mk = v;
    end
  endfunction

  task automatic set_cfg(input int v);
    int n = 0; bit ch;
    ch = (v <= 4 && v != mk);
    @(negedge clk);
    cfg_we = 1; cfg_blocks = 3'(v);
    @(negedge clk);
    cfg_we = 0;
    while (busy) begin n++; @(negedge clk); end
    m_cfg(v);
    chk(n == (ch ? 32 : 0), "R4 busy length", n, ch ? 32 : 0);
    chk(int'(cfg_cur) == mk, "R2 cfg_cur", {29'd0, cfg_cur}, mk);
  endtask

  int cfgseq [7] = '{3, 1, 4, 0, 2, 2, 5};

  initial begin
    logic [31:0] ar; bit ae; int at, lat;
    int seed = 7;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cfg_cur == 0, "R10 cfg_cur", {29'd0, cfg_cur}, 0);
    chk(!busy && !ready && !mem_req, "R10 idle outputs", {busy, ready, mem_req}, 0);
    rst_n = 1;
    // R1 SRAM in every block with k=0, R7 bypass
    for (int b = 0; b < 4; b++) run_acc(1, b * 1024 + 8, 32'hA000 + b, "R1 write");
    for (int b = 0; b < 4; b++) run_acc(0, b * 1024 + 8, 0, "R1 read");
    run_acc(0, 'h8040, 0, "R7 bypass read");
    run_acc(0, 'h8040, 0, "R7 bypass read again");
    run_acc(1, 'h8044, 32'h1234_5678, "R6 bypass write");
    run_acc(0, 'h8044, 0, "R7 read after write");
    // R2 ignored values
    set_cfg(5);
    set_cfg(0);
    // R4 / R11 / R3
    set_cfg(2);
    run_acc(0, 8, 0, "R11 block0 kept");
    run_acc(0, 1024 + 8, 0, "R11 block1 kept");
    run_acc(0, 2048 + 8, 0, "R3 block2 is cache");
    run_acc(1, 3072 + 8, 32'hDEAD, "R3 block3 write refused");
    // R5 / R9 with two ways
    run_acc(0, 'h8060, 0, "R5 miss");
    run_acc(0, 'h8064, 0, "R5 hit");
    run_acc(0, 'h8460, 0, "R8 second way");
    run_acc(0, 'h8060, 0, "R8 both resident");
    run_acc(0, 'h8860, 0, "R9 evict lru");
    run_acc(0, 'h8460, 0, "R9 evicted line misses");
    // R6 write-through
    run_acc(1, 'h8868, 32'hCAFE_0001, "R6 write hit");
    run_acc(0, 'h8868, 0, "R6 read updated word");
    run_acc(1, 'h9000, 32'hCAFE_0002, "R6 write miss");
    run_acc(0, 'h9000, 0, "R6 no allocate");
    // R3 alias into way 0
    set_cfg(4);
    run_acc(0, 'h80A0, 0, "R3 fill way0");
    run_acc(1, 'h0CA0, 32'hBAD0_BAD0, "R3 aliased write");
    run_acc(0, 'h80A0, 0, "R3 cached line intact");
    // R9 four-way tree sequence in set 2
    for (int t = 0; t < 4; t++) run_acc(0, 'h8000 + t * 1024 + 64, 0, "R8 fill four ways");
    run_acc(0, 'h8040, 0, "R9 touch way0");
    run_acc(0, 'h9040, 0, "R9 tree victim");
    run_acc(0, 'h8840, 0, "R9 tree victim 2");
    run_acc(0, 'h8440, 0, "R9 tree victim 3");
    run_acc(0, 'h8C40, 0, "R9 tree victim 4");
    // R4 invalidation and request held off during the sweep
    begin
      logic [31:0] xr; bit xe, cd; int xt;
      @(negedge clk); cfg_we = 1; cfg_blocks = 3'd3;
      @(negedge clk); cfg_we = 0;
      m_cfg(3);
      m_access(0, 8, 0, xr, xe, xt, cd);
      do_access(0, 8, 0, ar, ae, at, lat);
      chk(lat >= 30, "R4 request waits for sweep", lat, 30);
      chk(ar == xr, "R11 SRAM after change", ar, xr);
    end
    run_acc(0, 'h80A0, 0, "R4 line invalidated");
    // mixed traffic across all splits
    for (int i = 0; i < 420; i++) begin
      int r, a; bit w;
      if (i % 60 == 0) set_cfg(cfgseq[i / 60]);
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 32'h7FFFFF;
      w = ((r >> 20) % 4) == 0;
      if (r % 4 == 0) a = ((r >> 2) % 1024) * 4;
      else a = 'h8000 + ((r >> 10) % 6) * 1024 + ((r >> 13) % 4) * 32 + ((r >> 15) % 8) * 4;
      run_acc(w, a, 32'(r) ^ 32'h5500_0000, "R8 R9 mixed traffic");
    end
    set_cfg(0);
    run_acc(0, 'h8000, 0, "R7 bypass after cache");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule